// File: doc/BRIEF.md
# Stop-Mode Exit Sequencer

This block decides when a microcontroller core may run again after it has been put to sleep in stop mode. A stop request parks the core with its run enable low. When a wakeup event or an external reset pulse arrives, the block counts a stabilization window of internal clock cycles and only then raises the run enable again, marking that cycle with a one-cycle ready pulse. The window is short or long depending on a configuration bit, but an exit brought about by the external reset always waits the long window.

The same configuration word also controls the low-voltage detector. It selects the detector's threshold range, switches its power, and decides whether a trip asks for a system reset. The block also flags a forbidden setting: a short window while the external oscillator is set to halt during stop. The word can be written once after power-on reset. Writes after that are ignored until the next power-on reset.

Configuration word layout (`cfg_data_i`): bit 0 = short window, bit 1 = trip-reset disable, bit 2 = detector power-off, bit 3 = high-voltage range, bit 4 = oscillator keeps running in stop. After power-on reset the word is all zeros.

Top module: `stop_exit_seq`

## Requirements
- R1: After power-on reset `cpu_run_o`=1, `ready_o`=0, `sys_rst_o`=0, `lvd_en_o`=1, `lvd_hv_o`=0 and `cfg_err_o`=0.
- R2: `stop_req_i` sampled high while running, with `ext_rst_i` low, drives `cpu_run_o` low from the next cycle. It stays low while no wake or reset event arrives.
- R3: With bit 0 = 1, a `wake_i` sampled in stop at edge E0 raises `cpu_run_o` after edge E0+32 and not before.
- R4: With bit 0 = 0, the same exit raises `cpu_run_o` after edge E0+4096.
- R5: `ext_rst_i` sampled in stop starts the window, and the window lasts 4096 cycles whatever bit 0 holds.
- R6: During the window, `ext_rst_i` restarts it with 4096 cycles counted from that edge, and `wake_i` has no effect.
- R7: `ready_o` is high for exactly one cycle: the first cycle in which `cpu_run_o` is high again after a window.
- R8: With bit 2 = 0 and bit 1 = 0, `lv_trip_i` sampled high gives `sys_rst_o`=1 in the next cycle. With bit 1 = 1, a trip never raises `sys_rst_o`.
- R9: With bit 2 = 1, `lvd_en_o`=0 and `lv_trip_i` never raises `sys_rst_o`. With bit 2 = 0, `lvd_en_o`=1.
- R10: `lvd_hv_o` equals bit 3 of the stored configuration word.
- R11: `cfg_err_o` is 1 exactly when the stored word has bit 0 = 1 and bit 4 = 0.
- R12: Only the first `cfg_wr_i` after power-on reset stores `cfg_data_i`. Later writes leave every configuration-driven output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| stop_req_i | input | 1 | Request to enter stop mode |
| wake_i | input | 1 | Wakeup event (interrupt) |
| ext_rst_i | input | 1 | External reset pulse; forces the long window |
| lv_trip_i | input | 1 | Low-voltage detector trip |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 5 | Configuration word |
| cpu_run_o | output | 1 | Core run/clock enable |
| sys_rst_o | output | 1 | System reset request from a trip |
| lvd_en_o | output | 1 | Detector power enable |
| lvd_hv_o | output | 1 | Detector threshold range, 1 = high-voltage range |
| cfg_err_o | output | 1 | Forbidden configuration seen |
| ready_o | output | 1 | One-cycle pulse when the core resumes |

## Verification
The hardest case to reach is an external reset that lands in the middle of a short window. The bench has to lock a short-window configuration, stop the core, wake it, and then hit the window while the count is partway through. It does this with a directed sequence. The reset is fired a few cycles into a 32-cycle window, and wake pulses are scattered across the restarted window. The bench then checks that the rise comes exactly 4096 edges after the reset and not at the original 32-cycle mark.

// File: rtl/stop_exit_pkg.sv
package stop_exit_pkg;
    localparam int CFG_W      = 5;
    localparam int B_SHORT    = 0;
    localparam int B_RST_DIS  = 1;
    localparam int B_PWR_OFF  = 2;
    localparam int B_HV       = 3;
    localparam int B_OSC_RUN  = 4;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic short_win;
        logic rst_dis;
        logic pwr_off;
        logic hv;
        logic osc_run;
    } cfg_fields_t;
endpackage

// File: rtl/stop_exit_cfg.sv
module stop_exit_cfg
    import stop_exit_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] data_i,
    output cfg_fields_t      cfg_o
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic             locked;
    } cfg_reg_t;

    cfg_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i && !r_q.locked) begin
            r_d.word   = data_i;
            r_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        cfg_o.short_win = r_q.word[B_SHORT];
        cfg_o.rst_dis   = r_q.word[B_RST_DIS];
        cfg_o.pwr_off   = r_q.word[B_PWR_OFF];
        cfg_o.hv        = r_q.word[B_HV];
        cfg_o.osc_run   = r_q.word[B_OSC_RUN];
    end

    p_write_once_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.locked |=> $stable(r_q.word) && r_q.locked);
endmodule

// File: rtl/stop_exit_timer.sv
module stop_exit_timer #(
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic long_i,
    input  logic active_i,
    output logic done_o
);
    localparam int CNT_W = (LONG_CYC > SHORT_CYC) ? $clog2(LONG_CYC) : $clog2(SHORT_CYC);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             long_sel;
    } tmr_reg_t;

    tmr_reg_t t_d, t_q;
    logic [CNT_W-1:0] last;

    assign last   = t_q.long_sel ? LONG_LAST : SHORT_LAST;
    assign done_o = active_i && !start_i && (t_q.cnt == last);

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.cnt      = '0;
            t_d.long_sel = long_i;
        end else if (active_i && !done_o) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> t_q.cnt <= last);
    p_long_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && !start_i) |=> $stable(t_q.long_sel));
endmodule

// File: rtl/stop_exit_seq.sv
module stop_exit_seq
    import stop_exit_pkg::*;
#(
    parameter int SHORT_CYC = 32,
    parameter int LONG_CYC  = 4096
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_req_i,
    input  logic             wake_i,
    input  logic             ext_rst_i,
    input  logic             lv_trip_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_data_i,
    output logic             cpu_run_o,
    output logic             sys_rst_o,
    output logic             lvd_en_o,
    output logic             lvd_hv_o,
    output logic             cfg_err_o,
    output logic             ready_o
);
    typedef struct packed {
        seq_state_e st;
        logic       sys_rst;
        logic       ready;
    } seq_reg_t;

    seq_reg_t    s_d, s_q;
    cfg_fields_t cfg;
    logic        start, start_long, done;

    stop_exit_cfg u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (cfg_wr_i),
        .data_i (cfg_data_i),
        .cfg_o  (cfg)
    );

    stop_exit_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .long_i   (start_long),
        .active_i (s_q.st == ST_RECOVER),
        .done_o   (done)
    );

    always_comb begin
        s_d         = s_q;
        s_d.ready   = 1'b0;
        start       = 1'b0;
        start_long  = 1'b1;
        s_d.sys_rst = lv_trip_i && !cfg.pwr_off && !cfg.rst_dis;
        unique case (s_q.st)
            ST_RUN: begin
                if (ext_rst_i) begin
                    start  = 1'b1;
                    s_d.st = ST_RECOVER;
                end else if (stop_req_i) begin
                    s_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (ext_rst_i) begin
                    start  = 1'b1;
                    s_d.st = ST_RECOVER;
                end else if (wake_i) begin
                    start      = 1'b1;
                    start_long = !cfg.short_win;
                    s_d.st     = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (ext_rst_i) begin
                    start = 1'b1;
                end else if (done) begin
                    s_d.st    = ST_RUN;
                    s_d.ready = 1'b1;
                end
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_RUN, sys_rst: 1'b0, ready: 1'b0};
        else         s_q <= s_d;
    end

    assign cpu_run_o = (s_q.st == ST_RUN);
    assign ready_o   = s_q.ready;
    assign sys_rst_o = s_q.sys_rst;
    assign lvd_en_o  = !cfg.pwr_off;
    assign lvd_hv_o  = cfg.hv;
    assign cfg_err_o = cfg.short_win && !cfg.osc_run;

    p_stop_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_run_o && stop_req_i && !ext_rst_i) |=> !cpu_run_o);
    p_ready_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> !ready_o);
    p_ready_at_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu_run_o) |-> ready_o);
    p_trip_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lv_trip_i && lvd_en_o && !cfg.rst_dis) |=> sys_rst_o);
    p_trip_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvd_en_o || cfg.rst_dis) |=> !sys_rst_o);
    p_rst_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cpu_run_o && ext_rst_i) |=> !cpu_run_o);
endmodule

// File: tb/stop_exit_seq_bench.sv
module stop_exit_seq_bench;
    localparam int TCLK    = 10;
    localparam int SHORT_N = 32;
    localparam int LONG_N  = 4096;
    localparam int WDOG    = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic stop_req = 0, wake = 0, ext_rst = 0, trip = 0, cfg_wr = 0;
    logic [4:0] cfg_data = '0;
    logic cpu_run, sys_rst, lvd_en, lvd_hv, cfg_err, ready;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    stop_exit_seq u_stop_exit_seq (
        .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .wake_i(wake),
        .ext_rst_i(ext_rst), .lv_trip_i(trip), .cfg_wr_i(cfg_wr), .cfg_data_i(cfg_data),
        .cpu_run_o(cpu_run), .sys_rst_o(sys_rst), .lvd_en_o(lvd_en), .lvd_hv_o(lvd_hv),
        .cfg_err_o(cfg_err), .ready_o(ready)
    );

    function automatic logic exp_rst(logic [4:0] c, logic t);
        return t && !c[2] && !c[1];
    endfunction
    function automatic logic exp_err(logic [4:0] c);
        return c[0] && !c[4];
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        stop_req = 0; wake = 0; ext_rst = 0; trip = 0; cfg_wr = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic write_cfg(input logic [4:0] c);
        cfg_data = c; cfg_wr = 1;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic check_cfg_outs(input logic [4:0] c, input string tag);
        chk(lvd_en, !c[2], {tag, " R9 lvd_en"});
        chk(lvd_hv, c[3], {tag, " R10 lvd_hv"});
        chk(cfg_err, exp_err(c), {tag, " R11 cfg_err"});
    endtask

    task automatic enter_stop(input string tag);
        stop_req = 1;
        @(negedge clk); stop_req = 0;
        chk(cpu_run, 0, {tag, " R2 stopped"});
    endtask

    // Count edges after the event edge until cpu_run rises; checks the ready pulse.
    task automatic measure(output int n, input string tag);
        n = 0;
        while (!cpu_run && n < LONG_N + 10) begin
            @(negedge clk); n++;
            if (!cpu_run) chk(ready, 0, {tag, " R7 no early ready"});
        end
        chk(ready, 1, {tag, " R7 ready at rise"});
        @(negedge clk);
        chk(ready, 0, {tag, " R7 ready single"});
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [4:0] c, c2;
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R1 reset state
        chk(cpu_run, 1, "R1 cpu_run"); chk(ready, 0, "R1 ready");
        chk(sys_rst, 0, "R1 sys_rst"); chk(lvd_en, 1, "R1 lvd_en");
        chk(lvd_hv, 0, "R1 lvd_hv"); chk(cfg_err, 0, "R1 cfg_err");

        // R4 long window from wake with short=0
        write_cfg(5'b10000);
        enter_stop("R4");
        repeat (5) @(negedge clk);
        chk(cpu_run, 0, "R2 held in stop");
        wake = 1; @(negedge clk); wake = 0;
        measure(n, "R4"); chk(n, LONG_N, "R4 long window");

        // R5 ext reset in stop with short=1
        do_reset(); write_cfg(5'b10001);
        enter_stop("R5");
        ext_rst = 1; @(negedge clk); ext_rst = 0;
        measure(n, "R5"); chk(n, LONG_N, "R5 reset exit long");

        // R6 reset in the middle of a short window, wakes ignored
        enter_stop("R6");
        wake = 1; @(negedge clk); wake = 0;
        repeat (9) @(negedge clk);
        ext_rst = 1; @(negedge clk); ext_rst = 0;
        n = 0;
        for (int k = 0; k < 100; k++) begin
            wake = (k % 7 == 3); @(negedge clk); n++;
        end
        wake = 0;
        chk(cpu_run, 0, "R6 short window overridden");
        while (!cpu_run && n < LONG_N + 10) begin @(negedge clk); n++; end
        chk(n, LONG_N, "R6 restarted long window");

        // R12 second write ignored
        do_reset(); write_cfg(5'b01001);
        check_cfg_outs(5'b01001, "R12 first");
        write_cfg(5'b00110);
        check_cfg_outs(5'b01001, "R12 after second");

        // Random configurations
        for (int it = 0; it < 200; it++) begin
            c  = 5'($urandom);
            c2 = 5'($urandom);
            do_reset();
            write_cfg(c);
            check_cfg_outs(c, "rand");
            write_cfg(c2);
            check_cfg_outs(c, "R12 rand relock");
            for (int k = 0; k < 6; k++) begin
                trip = 1'($urandom);
                @(negedge clk);
                chk(sys_rst, exp_rst(c, trip), "R8 R9 trip");
            end
            trip = 0; @(negedge clk);
            if (c[0]) begin
                enter_stop("R3");
                wake = 1; @(negedge clk); wake = 0;
                measure(n, "R3"); chk(n, SHORT_N, "R3 short window");
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule